// File: doc/BRIEF.md
# Tape Command Decoder and Status

This block is the command side of a nine-track tape controller on a host I/O bus. The host writes an 8-bit function code. The block checks that code against the state of the drive. It then either starts a drive operation, by pulsing `startPulse` with the latched function on `startFunc`, or sets a reject bit and starts nothing. One special code clears the controller instead of starting anything. It aborts whatever is running and clears control and flags on both the command channel and the data channel.

The block holds a 9-bit status word that the host reads at any time. Some bits are latched: end of file, load point, end of tape, timing error, command reject and parity error. The rest are taken live from the drive and from the operation state: local, write locked and busy. The block also owns the command-channel flag and the command-channel control bit. When an operation finishes, the drive side reports it with `opDone`. The block then clears busy and raises the flag in the same edge. The exception is rewind-and-offline, which ends without raising the flag. Moving record data and emulating the medium are handled elsewhere.

Top module: `tape_cmd_status`

## Requirements
- R1: After reset, the flag, control bit, first-service and transfer flip-flops are clear and no start pulse is present. The only latched status bit that is set is load point (bit 6). With an attached, unlocked drive, the status reads 0x040.
- R2: Nine codes are recognised, in octal: 031 write, 023 read, 011 gap, 003 space forward, 041 space back, 201 rewind, 101 rewind-offline, 035 file mark, and 300 clear. An accepted command has these effects on the next edge:
  - `startPulse` is high for one cycle and `startFunc` equals the code.
  - All latched status bits are cleared, so the status shows busy only (0x001).
  - The flag is cleared.
  - `dataFlagClr` pulses.
  - The first-service and transfer flip-flops are set.
- R3: Every other code is rejected. Reject sets status bit 3, and neither a start pulse nor any other state change follows.
- R4: Any command other than clear is rejected while an operation is active.
- R5: Space back (041) is rejected while the load-point bit is set. It is accepted once an accepted command has cleared that bit.
- R6: With the drive attached and write locked, write (031), gap (011) and file mark (035) are rejected. Other valid codes are still accepted.
- R7: Every command write clears the reject bit before the new command is judged. A write that is accepted therefore leaves bit 3 at 0.
- R8: On `opDone` while an operation is active, busy clears and the flag sets on the same edge. For file mark, the end-of-file bit (7) is also set.
- R9: When a rewind (201) completes, the latched status becomes load point only. When rewind-offline (101) completes, busy clears but the flag stays clear.
- R10: Clear (300) is taken even while busy. It has these effects:
  - The operation is ended; a later `opDone` is ignored.
  - Both flip-flops are cleared.
  - Every latched bit except load point is cleared.
  - The flag and control bit are cleared.
  - `dataFlagClr` and `dataCtlClr` pulse.
- R11: Three status bits are live:
  - Bit 8 (local) equals not-attached.
  - Bit 2 (write locked) equals attached and locked.
  - Bit 0 (busy) equals not-attached or operation active.
- R12: Host requests set and clear the control bit and the flag. A clear request wins over a set request in the same cycle.
- R13: The `driveErr` inputs are sticky into the status: bit 0 of the input goes to status bit 1 (parity), bit 1 to status bit 4 (timing), and bit 2 to status bit 5 (end of tape).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Host writes a function code this cycle |
| cmdCode | input | 8 | Function code written by host |
| driveAttached | input | 1 | Drive is online |
| driveWrLocked | input | 1 | Drive medium is write locked |
| opDone | input | 1 | Drive side reports the current operation finished |
| driveErr | input | 3 | Sticky error events {end of tape, timing, parity} |
| ctlSetReq | input | 1 | Host sets command control bit |
| ctlClrReq | input | 1 | Host clears command control bit |
| flagSetReq | input | 1 | Host sets command flag |
| flagClrReq | input | 1 | Host clears command flag |
| statusWord | output | 9 | Status read by host |
| cmdFlag | output | 1 | Command-channel flag |
| cmdCtl | output | 1 | Command-channel control bit |
| startPulse | output | 1 | One-cycle operation start |
| startFunc | output | 8 | Latched function code |
| firstSvc | output | 1 | First-service flip-flop |
| xferEn | output | 1 | Transfer flip-flop |
| dataFlagClr | output | 1 | Pulse clearing data-channel flag |
| dataCtlClr | output | 1 | Pulse clearing data-channel control |

## Verification
The hardest case to reach is a rejection that depends on context rather than on the code. Examples are a backspace that fails only because load point is still latched, or the same code later accepted once an accepted command has wiped that bit. Equally hard is a clear that lands in the middle of a running rewind, followed by a late `opDone` that must be ignored. The bench sweeps all 256 codes from reset, once with an unlocked drive and once with a locked drive. It then builds these sequences by chaining accepted and completed commands before issuing the probe code.

// File: rtl/tape_cmd_pkg.sv
package tape_cmd_pkg;
  localparam int CODE_W = 8;
  localparam int STS_W  = 9;
  localparam int ERR_W  = 3;

  localparam logic [CODE_W-1:0] FN_CLEAR  = 8'o300;
  localparam logic [CODE_W-1:0] FN_WRITE  = 8'o031;
  localparam logic [CODE_W-1:0] FN_READ   = 8'o023;
  localparam logic [CODE_W-1:0] FN_GAP    = 8'o011;
  localparam logic [CODE_W-1:0] FN_FWD    = 8'o003;
  localparam logic [CODE_W-1:0] FN_BACK   = 8'o041;
  localparam logic [CODE_W-1:0] FN_REW    = 8'o201;
  localparam logic [CODE_W-1:0] FN_REWOFF = 8'o101;
  localparam logic [CODE_W-1:0] FN_MARK   = 8'o035;

  localparam int B_LOCAL = 8;
  localparam int B_EOF   = 7;
  localparam int B_BOT   = 6;
  localparam int B_EOT   = 5;
  localparam int B_TIM   = 4;
  localparam int B_REJ   = 3;
  localparam int B_WLK   = 2;
  localparam int B_PAR   = 1;
  localparam int B_BUSY  = 0;

  typedef struct packed {
    logic loadFunc;
    logic wipeStatus;
    logic keepBot;
    logic setReject;
    logic clrReject;
    logic rewDone;
    logic markDone;
  } dpStrobe_t;

  function automatic logic isKnownOp(input logic [CODE_W-1:0] c);
    return (c == FN_WRITE) || (c == FN_READ) || (c == FN_GAP) ||
           (c == FN_FWD) || (c == FN_BACK) || (c == FN_REW) ||
           (c == FN_REWOFF) || (c == FN_MARK);
  endfunction

  function automatic logic isWriteClass(input logic [CODE_W-1:0] c);
    return (c == FN_WRITE) || (c == FN_GAP) || (c == FN_MARK);
  endfunction
endpackage

// File: rtl/tcs_control.sv
module tcs_control
  import tape_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdWrEn,
  input  logic [CODE_W-1:0] cmdCode,
  input  logic              driveAttached,
  input  logic              driveWrLocked,
  input  logic              opDone,
  input  logic              ctlSetReq,
  input  logic              ctlClrReq,
  input  logic              flagSetReq,
  input  logic              flagClrReq,
  input  logic [CODE_W-1:0] curFunc,
  input  logic              atBot,
  output dpStrobe_t         strobe,
  output logic              opActive,
  output logic              cmdFlag,
  output logic              cmdCtl,
  output logic              firstSvc,
  output logic              xferEn,
  output logic              startPulse,
  output logic              dataFlagClr,
  output logic              dataCtlClr
);
  logic isClear, tryCmd, rejectNow, acceptNow, finishNow, lockedNow;

  always_comb begin
    isClear   = cmdWrEn && (cmdCode == FN_CLEAR);
    tryCmd    = cmdWrEn && !isClear;
    lockedNow = driveAttached && driveWrLocked;
    rejectNow = tryCmd && (!isKnownOp(cmdCode) || opActive ||
                ((cmdCode == FN_BACK) && atBot) ||
                (lockedNow && isWriteClass(cmdCode)));
    acceptNow = tryCmd && !rejectNow;
    finishNow = opDone && opActive && !isClear;

    strobe.loadFunc   = acceptNow;
    strobe.wipeStatus = acceptNow;
    strobe.keepBot    = isClear;
    strobe.setReject  = rejectNow;
    strobe.clrReject  = cmdWrEn;
    strobe.rewDone    = finishNow && (curFunc == FN_REW);
    strobe.markDone   = finishNow && (curFunc == FN_MARK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opActive    <= 1'b0;
      cmdFlag     <= 1'b0;
      cmdCtl      <= 1'b0;
      firstSvc    <= 1'b0;
      xferEn      <= 1'b0;
      startPulse  <= 1'b0;
      dataFlagClr <= 1'b0;
      dataCtlClr  <= 1'b0;
    end else begin
      startPulse  <= acceptNow;
      dataFlagClr <= acceptNow || isClear;
      dataCtlClr  <= isClear;

      if (acceptNow)                  opActive <= 1'b1;
      else if (isClear || finishNow)  opActive <= 1'b0;

      if (isClear || acceptNow || flagClrReq)
        cmdFlag <= 1'b0;
      else if ((finishNow && (curFunc != FN_REWOFF)) || flagSetReq)
        cmdFlag <= 1'b1;

      if (isClear || ctlClrReq) cmdCtl <= 1'b0;
      else if (ctlSetReq)       cmdCtl <= 1'b1;

      if (acceptNow) begin
        firstSvc <= 1'b1;
        xferEn   <= 1'b1;
      end else if (isClear) begin
        firstSvc <= 1'b0;
        xferEn   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tcs_datapath.sv
module tcs_datapath
  import tape_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [CODE_W-1:0] cmdCode,
  input  logic [ERR_W-1:0]  driveErr,
  input  logic              driveAttached,
  input  logic              driveWrLocked,
  input  logic              opActive,
  output logic [CODE_W-1:0] curFunc,
  output logic              atBot,
  output logic [STS_W-1:0]  statusWord
);
  localparam logic [STS_W-1:0] LIVE_MASK = STS_W'((1 << B_LOCAL) | (1 << B_WLK) | (1 << B_BUSY));
  localparam logic [STS_W-1:0] BOT_ONLY  = STS_W'(1 << B_BOT);

  logic [STS_W-1:0] held, heldNext, liveBits;

  always_comb begin
    heldNext = held;
    if (strobe.clrReject)  heldNext[B_REJ] = 1'b0;
    if (strobe.wipeStatus) heldNext = '0;
    if (strobe.keepBot)    heldNext = heldNext & BOT_ONLY;
    if (strobe.setReject)  heldNext[B_REJ] = 1'b1;
    if (strobe.rewDone)    heldNext = BOT_ONLY;
    if (strobe.markDone)   heldNext[B_EOF] = 1'b1;
    if (driveErr[0])       heldNext[B_PAR] = 1'b1;
    if (driveErr[1])       heldNext[B_TIM] = 1'b1;
    if (driveErr[2])       heldNext[B_EOT] = 1'b1;
    heldNext = heldNext & ~LIVE_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= BOT_ONLY;
      curFunc <= '0;
    end else begin
      held <= heldNext;
      if (strobe.loadFunc) curFunc <= cmdCode;
    end
  end

  always_comb begin
    liveBits         = '0;
    liveBits[B_LOCAL] = !driveAttached;
    liveBits[B_WLK]   = driveAttached && driveWrLocked;
    liveBits[B_BUSY]  = !driveAttached || opActive;
    statusWord       = held | liveBits;
    atBot            = held[B_BOT];
  end
endmodule

// File: rtl/tape_cmd_status.sv
module tape_cmd_status
  import tape_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdWrEn,
  input  logic [CODE_W-1:0] cmdCode,
  input  logic              driveAttached,
  input  logic              driveWrLocked,
  input  logic              opDone,
  input  logic [ERR_W-1:0]  driveErr,
  input  logic              ctlSetReq,
  input  logic              ctlClrReq,
  input  logic              flagSetReq,
  input  logic              flagClrReq,
  output logic [STS_W-1:0]  statusWord,
  output logic              cmdFlag,
  output logic              cmdCtl,
  output logic              startPulse,
  output logic [CODE_W-1:0] startFunc,
  output logic              firstSvc,
  output logic              xferEn,
  output logic              dataFlagClr,
  output logic              dataCtlClr
);
  dpStrobe_t         strobe;
  logic              opActive, atBot;
  logic [CODE_W-1:0] curFunc;

  tcs_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdWrEn(cmdWrEn), .cmdCode(cmdCode),
    .driveAttached(driveAttached), .driveWrLocked(driveWrLocked),
    .opDone(opDone), .ctlSetReq(ctlSetReq), .ctlClrReq(ctlClrReq),
    .flagSetReq(flagSetReq), .flagClrReq(flagClrReq),
    .curFunc(curFunc), .atBot(atBot), .strobe(strobe),
    .opActive(opActive), .cmdFlag(cmdFlag), .cmdCtl(cmdCtl),
    .firstSvc(firstSvc), .xferEn(xferEn), .startPulse(startPulse),
    .dataFlagClr(dataFlagClr), .dataCtlClr(dataCtlClr)
  );

  tcs_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cmdCode(cmdCode),
    .driveErr(driveErr), .driveAttached(driveAttached),
    .driveWrLocked(driveWrLocked), .opActive(opActive),
    .curFunc(curFunc), .atBot(atBot), .statusWord(statusWord)
  );

  assign startFunc = curFunc;
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker
  import tape_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmdWrEn,
  input logic [CODE_W-1:0] cmdCode,
  input logic              driveAttached,
  input logic [STS_W-1:0]  statusWord,
  input logic              cmdFlag,
  input logic              cmdCtl,
  input logic              startPulse,
  input logic              firstSvc,
  input logic              xferEn,
  input logic              dataFlagClr,
  input logic              dataCtlClr
);
  p_start_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> (!cmdFlag && firstSvc && xferEn && dataFlagClr));

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> !startPulse);

  p_busy_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWrEn && (cmdCode != FN_CLEAR) && driveAttached && statusWord[B_BUSY])
      |=> (!startPulse && statusWord[B_REJ]));

  p_clear_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWrEn && (cmdCode == FN_CLEAR))
      |=> (!cmdFlag && !cmdCtl && dataCtlClr && dataFlagClr && !firstSvc &&
           !xferEn && !statusWord[B_EOF] && !statusWord[B_REJ]));

  p_offline_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !driveAttached |-> (statusWord[B_LOCAL] && statusWord[B_BUSY] && !statusWord[B_WLK]));
endmodule

bind tape_cmd_status tcs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmdWrEn(cmdWrEn), .cmdCode(cmdCode),
  .driveAttached(driveAttached), .statusWord(statusWord),
  .cmdFlag(cmdFlag), .cmdCtl(cmdCtl), .startPulse(startPulse),
  .firstSvc(firstSvc), .xferEn(xferEn), .dataFlagClr(dataFlagClr),
  .dataCtlClr(dataCtlClr)
);

// File: tb/test_tape_cmd_status.sv
`timescale 1ns/1ps
module test_tape_cmd_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmdWrEn = 1'b0;
  logic [7:0] cmdCode = 8'h00;
  logic       driveAttached = 1'b1;
  logic       driveWrLocked = 1'b0;
  logic       opDone = 1'b0;
  logic [2:0] driveErr = 3'b000;
  logic       ctlSetReq = 1'b0, ctlClrReq = 1'b0, flagSetReq = 1'b0, flagClrReq = 1'b0;
  logic [8:0] statusWord;
  logic       cmdFlag, cmdCtl, startPulse, firstSvc, xferEn, dataFlagClr, dataCtlClr;
  logic [7:0] startFunc;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tape_cmd_status i_tape_cmd_status (
    .clk(clk), .rst_n(rst_n), .cmdWrEn(cmdWrEn), .cmdCode(cmdCode),
    .driveAttached(driveAttached), .driveWrLocked(driveWrLocked),
    .opDone(opDone), .driveErr(driveErr), .ctlSetReq(ctlSetReq),
    .ctlClrReq(ctlClrReq), .flagSetReq(flagSetReq), .flagClrReq(flagClrReq),
    .statusWord(statusWord), .cmdFlag(cmdFlag), .cmdCtl(cmdCtl),
    .startPulse(startPulse), .startFunc(startFunc), .firstSvc(firstSvc),
    .xferEn(xferEn), .dataFlagClr(dataFlagClr), .dataCtlClr(dataCtlClr)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit known(input logic [7:0] c);
    return c == 8'o031 || c == 8'o023 || c == 8'o011 || c == 8'o003 ||
           c == 8'o041 || c == 8'o201 || c == 8'o101 || c == 8'o035;
  endfunction

  function automatic bit wclass(input logic [7:0] c);
    return c == 8'o031 || c == 8'o011 || c == 8'o035;
  endfunction

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic issue(input logic [7:0] c);
    @(negedge clk); cmdWrEn = 1'b1; cmdCode = c;
    @(negedge clk); cmdWrEn = 1'b0;
  endtask

  task automatic finishOp();
    @(negedge clk); opDone = 1'b1;
    @(negedge clk); opDone = 1'b0;
  endtask

  task automatic sweep(input bit locked);
    for (int c = 0; c < 256; c++) begin
      logic [7:0] code;
      bit acc;
      int base;
      code = 8'(c);
      driveWrLocked = locked;
      base = locked ? 'h044 : 'h040;
      doReset();
      if (c == 0) begin
        chk("R1 reset status", statusWord, base);
        chk("R1 reset flag/ctl/ff", {cmdFlag, cmdCtl, firstSvc, xferEn, startPulse}, 0);
      end
      acc = known(code) && code != 8'o041 && !(locked && wclass(code));
      issue(code);
      if (code == 8'o300) begin
        chk("R10 clear at idle status", statusWord, base);
        chk("R10 clear pulses", {dataCtlClr, dataFlagClr, startPulse}, 3'b110);
      end else if (acc) begin
        chk("R2 start pulse", startPulse, 1);
        chk("R2 start func", startFunc, code);
        chk("R2 busy-only status", statusWord, locked ? 'h005 : 'h001);
        chk("R2 ffs and data flag clear", {firstSvc, xferEn, dataFlagClr, cmdFlag}, 4'b1110);
        finishOp();
        if (code == 8'o201) chk("R9 rewind done status", statusWord, base);
        else if (code == 8'o035) chk("R8 mark done status", statusWord, base - 'h040 + 'h080);
        else chk("R8 done status", statusWord, base - 'h040);
        chk(code == 8'o101 ? "R9 offline no flag" : "R8 flag set", cmdFlag, code == 8'o101 ? 0 : 1);
      end else begin
        chk(locked && wclass(code) ? "R6 locked reject" :
            (code == 8'o041 ? "R5 back at BOT reject" : "R3 unknown reject"),
            statusWord, base | 'h008);
        chk("R3 no start", {startPulse, firstSvc, xferEn, cmdFlag}, 0);
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    sweep(1'b0);
    sweep(1'b1);
    driveWrLocked = 1'b0;

    // R4 busy reject, R7 reject clearing, R5 back after BOT cleared
    doReset();
    issue(8'o023);
    issue(8'o003);
    chk("R4 busy reject", statusWord, 'h009);
    chk("R4 no start", startPulse, 0);
    finishOp();
    chk("R8 done keeps reject", statusWord, 'h008);
    issue(8'o041);
    chk("R7 reject cleared on accept", statusWord, 'h001);
    chk("R5 back accepted after BOT cleared", startFunc, 8'o041);
    finishOp();

    // R10 clear during rewind
    issue(8'o201);
    issue(8'o300);
    chk("R10 clear mid-op status", statusWord, 'h000);
    chk("R10 clear mid-op outputs", {cmdFlag, firstSvc, xferEn, dataCtlClr, dataFlagClr}, 5'b00011);
    finishOp();
    chk("R10 late opDone ignored", {cmdFlag, statusWord}, 0);

    // R12 control and flag requests
    @(negedge clk); ctlSetReq = 1; flagSetReq = 1;
    @(negedge clk); ctlSetReq = 0; flagSetReq = 0;
    chk("R12 set ctl/flag", {cmdCtl, cmdFlag}, 2'b11);
    @(negedge clk); ctlClrReq = 1; ctlSetReq = 1; flagClrReq = 1; flagSetReq = 1;
    @(negedge clk); ctlClrReq = 0; ctlSetReq = 0; flagClrReq = 0; flagSetReq = 0;
    chk("R12 clear wins", {cmdCtl, cmdFlag}, 2'b00);

    // R13 sticky errors, wiped by accept
    doReset();
    @(negedge clk); driveErr = 3'b111;
    @(negedge clk); driveErr = 3'b000;
    @(negedge clk);
    chk("R13 sticky errors", statusWord, 'h072);
    issue(8'o003);
    chk("R13 wiped by accept", statusWord, 'h001);
    finishOp();

    // R11 live bits
    driveAttached = 1'b0; driveWrLocked = 1'b1;
    @(negedge clk);
    chk("R11 offline live bits", statusWord, 'h101);
    driveAttached = 1'b1;
    @(negedge clk);
    chk("R11 locked live bit", statusWord, 'h004);
    driveWrLocked = 1'b0;

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule